// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Transmitter

This block sends data words out on one serial data pin. An outside master supplies the bit clock, so the block has no baud source of its own. The host writes words into a one-word holding register. That register feeds a shift register, so the host can queue the next word while the current one is still leaving. Frames are 8 bits, or 9 bits when the ninth-bit mode is chosen at write time.

The external clock is brought into the system clock domain with a synchroniser. Only its falling edges are used: each one moves the next bit onto the pin, so the master samples it on the following rising edge. A buffer-empty flag, with its own interrupt enable, tells the host when it may write again. A shift-empty status bit tells it when the line has gone quiet. Transmission runs only when all of these hold:

- the port is enabled;
- the synchronous mode is selected;
- the clock source is set to external;
- both receive enables are off;
- transmit is enabled.

Top module: `sync_slave_tx`

## Requirements
- R1: After reset `buf_empty`=1, `shift_empty`=1, `irq`=0 and `data_o`=1.
- R2: The block is active only while `port_en`=1, `sync_mode`=1, `clk_master`=0, `rx_cont_en`=0, `rx_single_en`=0 and `tx_en`=1. A write presented while inactive is dropped, and neither flag changes.
- R3: A write accepted while both registers are empty goes straight into the shift register. `shift_empty` reads 0 from the next cycle, and `buf_empty` stays 1.
- R4: A write accepted while a word is shifting is parked in the holding register, and `buf_empty` reads 0 from the next cycle. A write made while the holding register is full is dropped.
- R5: Bits leave least significant first. Bit 0 is on `data_o` as soon as the word is loaded, and each later bit appears after one further falling edge of `ext_clk`.
- R6: With `nine_bit`=1 at write time, the frame has 9 bits and its last bit is the `ninth_bit` value captured with that write. With `nine_bit`=0 the frame has 8 bits.
- R7: At the falling edge that ends a frame, a parked word moves into the shift register and `buf_empty` returns to 1 at that moment. Its bit 0 follows on the pin with no gap.
- R8: `shift_empty` returns to 1 after the last bit of a frame has been shifted out, provided no word is parked.
- R9: `irq` is 1 exactly while `buf_empty`=1 and `irq_en`=1.
- R10: Leaving the active state aborts any frame in progress. Both registers are emptied, and `buf_empty` and `shift_empty` read 1.
- R11: `data_o` is held at 1 whenever the shift register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select |
| clk_master | input | 1 | Clock source select; 0 selects the external clock |
| rx_cont_en | input | 1 | Continuous receive enable; must be 0 to transmit |
| rx_single_en | input | 1 | Single receive enable; must be 0 to transmit |
| tx_en | input | 1 | Transmit enable |
| nine_bit | input | 1 | 9-bit frame select, captured with each write |
| ninth_bit | input | 1 | Ninth data bit, captured with each write |
| irq_en | input | 1 | Buffer-empty interrupt enable |
| wr_valid | input | 1 | One-cycle write strobe for `wr_data` |
| wr_data | input | 8 | Data word to send |
| ext_clk | input | 1 | External bit clock from the master |
| data_o | output | 1 | Serial data out |
| buf_empty | output | 1 | Holding register empty flag |
| shift_empty | output | 1 | Shift register empty status |
| irq | output | 1 | Interrupt request |

## Verification
The bench plays the master's role. It pulses `ext_clk` slowly and checks every frame against words it queued when writing them.

Six patterns are used:

- **Single word into an idle block.** Separates a direct load from a parked word.
- **Two writes in a row.** Shows the handover at the end of a frame and the moment `buf_empty` rises.
- **Three writes in a row.** Shows that the third write is dropped, not overwriting the parked word.
- **Two 9-bit frames with opposite ninth bits.** Shows the frame length and the captured ninth bit, and tells a real ninth bit apart from the idle-high line.
- **Frame cut off part way by clearing transmit enable.** Checks the abort path.
- **Writes made while a mode or receive control is wrong.** Checks the enable gating.

// File: rtl/sst_pkg.sv
// Shared word width and the type of a queued transmit word.
package sst_pkg;
    localparam int SST_DATA_W = 8;
    localparam int SST_CNT_W  = $clog2(SST_DATA_W + 1);

    // One word as captured at write time: frame length select, ninth bit, data.
    typedef struct packed {
        logic                  nine;
        logic                  ninth;
        logic [SST_DATA_W-1:0] data;
    } sst_word_t;
endpackage

// File: rtl/sst_edge_sync.sv
// Synchronises the external bit clock into the system clock domain and
// flags its falling edges with a one-cycle pulse.
// Assumes ext high and low times span several system clock periods.
// Flops reset to 1 (idle high), so reset never produces a false edge.
module sst_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the async input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], async_i};
    end

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/sst_hold_reg.sv
// One-word holding register in front of the shift register.
// When a push and a pop arrive together, the pushed word replaces the
// popped one and the register stays full. A clear overrides both.
module sst_hold_reg
    import sst_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear,
    input  logic      push,
    input  logic      pop,
    input  sst_word_t din,
    output sst_word_t dout,
    output logic      full
);
    sst_word_t word_q;
    logic      full_q;

    // Track occupancy and capture pushed words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            full_q <= 1'b0;
        end else if (clear) begin
            full_q <= 1'b0;
        end else if (push) begin
            word_q <= din;
            full_q <= 1'b1;
        end else if (pop) begin
            full_q <= 1'b0;
        end
    end

    assign dout = word_q;
    assign full = full_q;
endmodule

// File: rtl/sst_shifter.sv
// Shift register driven by external falling edges, sending LSB first.
// Bit 0 sits on the pin as soon as a word loads. Each falling edge moves
// one bit on. The falling edge that follows the last bit (8 or 9) ends
// the frame. The pin idles high while the register is empty.
module sst_shifter
    import sst_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear,
    input  logic      load,
    input  sst_word_t word,
    input  logic      fall,
    output logic      data_o,
    output logic      empty,
    output logic      last_fall
);
    logic [SST_DATA_W:0]  sreg_q;
    logic [SST_CNT_W-1:0] cnt_q;
    logic                 nine_q;
    logic                 empty_q;
    logic                 at_last;

    // The count sits on the final bit of the current frame length.
    assign at_last   = nine_q ? (cnt_q == SST_CNT_W'(SST_DATA_W))
                              : (cnt_q == SST_CNT_W'(SST_DATA_W - 1));
    assign last_fall = fall & ~empty_q & at_last;

    // Load, shift and end frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q  <= '0;
            cnt_q   <= '0;
            nine_q  <= 1'b0;
            empty_q <= 1'b1;
        end else if (clear) begin
            empty_q <= 1'b1;
        end else if (load) begin
            sreg_q  <= {word.ninth, word.data};
            cnt_q   <= '0;
            nine_q  <= word.nine;
            empty_q <= 1'b0;
        end else if (last_fall) begin
            empty_q <= 1'b1;
        end else if (fall && !empty_q) begin
            sreg_q <= {1'b0, sreg_q[SST_DATA_W:1]};
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign data_o = empty_q ? 1'b1 : sreg_q[0];
    assign empty  = empty_q;
endmodule

// File: rtl/sync_slave_tx.sv
// Externally clocked synchronous serial transmitter.
// Works out whether the block is active, routes host writes to the
// shift or holding register, and hands parked words over at frame end.
// Assumes wr_valid is a one-cycle strobe in the clk domain.
module sync_slave_tx
    import sst_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  port_en,
    input  logic                  sync_mode,
    input  logic                  clk_master,
    input  logic                  rx_cont_en,
    input  logic                  rx_single_en,
    input  logic                  tx_en,
    input  logic                  nine_bit,
    input  logic                  ninth_bit,
    input  logic                  irq_en,
    input  logic                  wr_valid,
    input  logic [SST_DATA_W-1:0] wr_data,
    input  logic                  ext_clk,
    output logic                  data_o,
    output logic                  buf_empty,
    output logic                  shift_empty,
    output logic                  irq
);
    logic      active, fall, last_fall, sh_empty, sh_free;
    logic      hold_full, wr_ok, load_wr, load_hold, hold_push;
    sst_word_t wr_word, hold_word, load_word;

    assign active = port_en & sync_mode & ~clk_master
                  & ~rx_cont_en & ~rx_single_en & tx_en;

    sst_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ext_clk), .fall_o(fall)
    );

    // Steering: a freeing shifter takes the parked word first, else the write.
    assign wr_ok     = active & wr_valid;
    assign wr_word   = '{nine: nine_bit, ninth: ninth_bit, data: wr_data};
    assign sh_free   = sh_empty | last_fall;
    assign load_hold = active & sh_free & hold_full;
    assign load_wr   = sh_free & ~hold_full & wr_ok;
    assign hold_push = wr_ok & ~load_wr & (~hold_full | load_hold);
    assign load_word = load_hold ? hold_word : wr_word;

    sst_hold_reg u_hold (
        .clk(clk), .rst_n(rst_n), .clear(~active), .push(hold_push),
        .pop(load_hold), .din(wr_word), .dout(hold_word), .full(hold_full)
    );

    sst_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .clear(~active),
        .load(load_hold | load_wr), .word(load_word), .fall(fall),
        .data_o(data_o), .empty(sh_empty), .last_fall(last_fall)
    );

    assign buf_empty   = ~hold_full;
    assign shift_empty = sh_empty;
    assign irq         = ~hold_full & irq_en;
endmodule

// File: rtl/sst_checker.sv
// Port-level properties of sync_slave_tx, attached by bind.
module sst_checker (
    input logic clk,
    input logic rst_n,
    input logic port_en,
    input logic sync_mode,
    input logic clk_master,
    input logic rx_cont_en,
    input logic rx_single_en,
    input logic tx_en,
    input logic wr_valid,
    input logic data_o,
    input logic buf_empty,
    input logic shift_empty
);
    logic act;
    assign act = port_en & sync_mode & ~clk_master & ~rx_cont_en & ~rx_single_en & tx_en;

    // R2, R10: inactive means both registers are empty one cycle later.
    a_r10_inactive_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> (shift_empty && buf_empty));

    // R3: the shifter only starts from empty because of a write.
    a_r3_load_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty) |-> $past(wr_valid));

    // R4: a word is parked only while the shifter is busy.
    a_r4_park_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_empty) |-> !shift_empty);

    // R8: the line goes quiet only with nothing parked.
    a_r8_quiet_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift_empty) |-> buf_empty);

    // R11: the idle line is high.
    a_r11_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> data_o);
endmodule

bind sync_slave_tx sst_checker u_chk (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
    .clk_master(clk_master), .rx_cont_en(rx_cont_en), .rx_single_en(rx_single_en),
    .tx_en(tx_en), .wr_valid(wr_valid), .data_o(data_o),
    .buf_empty(buf_empty), .shift_empty(shift_empty)
);

// File: tb/sync_slave_tx_test.sv
// Scoreboard bench: the write task queues expected frames, and the
// frame monitor plays master, clocks them out and compares.
module sync_slave_tx_test;
    localparam int HP = 8;  // ext_clk half period, in system clocks

    logic clk = 1'b0, rst_n = 1'b0;
    logic port_en = 1'b1, sync_mode = 1'b1, clk_master = 1'b0;
    logic rx_cont_en = 1'b0, rx_single_en = 1'b0, tx_en = 1'b1;
    logic nine_bit = 1'b0, ninth_bit = 1'b0, irq_en = 1'b0, wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic ext_clk = 1'b1;
    logic data_o, buf_empty, shift_empty, irq;

    int total = 0, bad = 0;
    logic [9:0] exp_q[$];

    always #5 clk = ~clk;

    sync_slave_tx uut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
        .clk_master(clk_master), .rx_cont_en(rx_cont_en), .rx_single_en(rx_single_en),
        .tx_en(tx_en), .nine_bit(nine_bit), .ninth_bit(ninth_bit), .irq_en(irq_en),
        .wr_valid(wr_valid), .wr_data(wr_data), .ext_clk(ext_clk),
        .data_o(data_o), .buf_empty(buf_empty), .shift_empty(shift_empty), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: one write strobe; queue the frame if it should be accepted.
    task automatic write_word(input logic [7:0] d, input logic nine, input logic n9,
                              input bit accept);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d; nine_bit = nine; ninth_bit = n9;
        @(negedge clk);
        wr_valid = 1'b0;
        if (accept) exp_q.push_back({nine, n9, d});
    endtask

    // Returns the line level sampled during the high phase, then drives one ext_clk pulse.
    task automatic pulse(output logic bit_seen);
        repeat (HP) @(negedge clk);
        bit_seen = data_o;
        ext_clk = 1'b0;
        repeat (HP) @(negedge clk);
        ext_clk = 1'b1;
    endtask

    // Monitor: pop one expected frame, clock it out as master, compare.
    task automatic run_frame(input string req);
        logic [9:0] item;
        logic [8:0] got, want;
        int len;
        logic b;
        item = exp_q.pop_front();
        len  = item[9] ? 9 : 8;
        want = item[9] ? item[8:0] : {1'b0, item[7:0]};
        got  = '0;
        for (int i = 0; i < len; i++) begin
            pulse(b);
            got[i] = b;
        end
        chk(req, {7'd0, got}, {7'd0, want});
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset", {buf_empty, shift_empty, irq, data_o}, 4'b1101);

        // R3: direct load into an idle block
        write_word(8'hA5, 1'b0, 1'b0, 1);
        chk("R3 direct load", {buf_empty, shift_empty}, 2'b10);
        // R4: second write is parked; R9: irq off while parked
        irq_en = 1'b1;
        write_word(8'h3C, 1'b0, 1'b0, 1);
        chk("R4 parked", {buf_empty, shift_empty}, 2'b00);
        chk("R9 irq low while full", {15'd0, irq}, 16'd0);
        // R5: LSB-first frame
        run_frame("R5 frame A5");
        // R7: handover at frame end, buffer empty again, irq raised
        chk("R7 handover", {buf_empty, shift_empty}, 2'b10);
        chk("R9 irq on empty", {15'd0, irq}, 16'd1);
        irq_en = 1'b0;
        @(negedge clk);
        chk("R9 irq masked", {15'd0, irq}, 16'd0);
        run_frame("R7 back-to-back frame 3C");
        // R8: quiet after last frame; R11: idle high
        chk("R8 drained", {buf_empty, shift_empty}, 2'b11);
        chk("R11 idle high", {15'd0, data_o}, 16'd1);

        // R6: 9-bit frames, ninth bit 0 then 1
        write_word(8'hFF, 1'b1, 1'b0, 1);
        write_word(8'h00, 1'b1, 1'b1, 1);
        run_frame("R6 nine-bit ninth=0");
        run_frame("R6 nine-bit ninth=1");
        chk("R8 drained after 9-bit", {15'd0, shift_empty}, 16'd1);

        // R4: third write while holding register full is dropped
        write_word(8'h81, 1'b0, 1'b0, 1);
        write_word(8'h42, 1'b0, 1'b0, 1);
        write_word(8'hE7, 1'b0, 1'b0, 0);
        run_frame("R4 first of three");
        run_frame("R4 second of three");
        repeat (HP) @(negedge clk);
        chk("R4 third write dropped", {buf_empty, shift_empty}, 2'b11);

        // R10: abort mid-frame by clearing tx_en
        write_word(8'h5A, 1'b0, 1'b0, 0);
        write_word(8'h11, 1'b0, 1'b0, 0);
        for (int i = 0; i < 3; i++) pulse(b);
        @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk("R10 abort", {buf_empty, shift_empty, data_o}, 3'b111);
        tx_en = 1'b1;
        pulse(b);
        chk("R10 nothing resumes", {shift_empty, b, data_o}, 3'b111);

        // R2: writes while inactive are dropped
        clk_master = 1'b1;
        write_word(8'h00, 1'b0, 1'b0, 0);
        chk("R2 master clock select", {buf_empty, shift_empty}, 2'b11);
        clk_master = 1'b0;
        rx_cont_en = 1'b1;
        write_word(8'h00, 1'b0, 1'b0, 0);
        chk("R2 receive enabled", {buf_empty, shift_empty}, 2'b11);
        rx_cont_en = 1'b0;
        @(negedge clk);
        chk("R2 still idle after re-enable", {buf_empty, shift_empty, data_o}, 3'b111);

        // R5: a further pattern after all the above
        write_word(8'h96, 1'b0, 1'b0, 1);
        run_frame("R5 frame 96");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule